// File: doc/BRIEF.md
# Segment address translation unit

This unit turns a segment reference and an offset into a linear address. A mode input picks one of two ways of doing it. In real mode the 16-bit segment value is moved up by four bit positions, so every segment begins on a 16-byte boundary, and the low 16 bits of the offset are added to it. Any offset that does not fit in a 64KB segment is rejected with a protection fault.

In protected mode the 16-bit segment input is read as a selector. Its index picks an 8-byte descriptor in either the global or the local descriptor table. Each table is described by a base and a limit register, and both can be written through dedicated ports. Before any memory access, the unit checks the descriptor's last byte against the chosen table's limit and rejects the null global selector. A valid descriptor is read as two 32-bit words over a valid/ready read port. The unit then gathers the segment base from the descriptor, adds the full 32-bit offset, and returns the result together with the requested privilege level.

Requests use a start/busy handshake. Every result, good or faulted, is marked by a one-cycle `done` pulse.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, done, busy, fault and mem_rd_valid are 0 and lin_addr is 0. Both tables have base 0 and limit 0, so any protected request is then rejected by the limit check.
- R2: With mode_prot=0, lin_addr = (seg_sel << 4) + offset[15:0], zero-extended. done pulses in the cycle after start, and busy stays 0.
- R3: In real mode the carry out of bit 19 is kept. Segment 0xFFFF with offset 0xFFFF gives 0x0010FFEF.
- R4: In real mode, an offset above 0xFFFF gives fault=1 and fault_code=13 in the cycle after start, with lin_addr forced to 0.
- R5: In protected mode, seg_sel[15:3] is the descriptor index and seg_sel[2] picks the table (0 global, 1 local). seg_sel[1:0] appears on rpl_out with done.
- R6: The first descriptor read is at table base + index*8 and the second at that address + 4. mem_rd_valid and mem_rd_addr hold steady until mem_rd_ready is seen.
- R7: If index*8+7 is greater than the chosen table's limit, the unit sets fault=1 with fault_code=13 in the cycle after start and issues no read.
- R8: A global selector with index 0 is rejected with fault_code=13 and issues no read. A local selector with index 0 is translated normally.
- R9: The segment base is built as follows: base[15:0] comes from bits 31:16 of the first word, base[23:16] from bits 7:0 of the second word, and base[31:24] from bits 31:24 of the second word. lin_addr = base + offset mod 2^32, with fault=0. done pulses in the cycle after the second read's handshake.
- R10: While busy=1, start is ignored. Exactly one done is produced, and it carries the earlier request's result.
- R11: gdt_wr loads the global table's base and limit from tbl_base_in and tbl_limit_in, and ldt_wr does the same for the local table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe |
| mode_prot | input | 1 | 0 real mode, 1 protected mode |
| seg_sel | input | 16 | Segment value or selector |
| offset | input | 32 | Effective offset |
| busy | output | 1 | Descriptor fetch in progress |
| done | output | 1 | One-cycle result pulse |
| lin_addr | output | 32 | Linear address result |
| rpl_out | output | 2 | Requested privilege level of the last request |
| fault | output | 1 | Last request faulted |
| fault_code | output | 8 | Fault number (13) or 0 |
| gdt_wr | input | 1 | Load global table registers |
| ldt_wr | input | 1 | Load local table registers |
| tbl_base_in | input | 32 | Table base write data |
| tbl_limit_in | input | 16 | Table limit write data |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_addr | output | 32 | Descriptor read address |
| mem_rd_ready | input | 1 | Read accepted; data valid |
| mem_rd_data | input | 32 | Read data |

## Verification
The bench sweeps segment values against offsets on both sides of 0xFFFF, including the largest sum. A design that dropped the bit-20 carry would wrap that sum to 0x0FFEF, and one that checked the wrong bound would either fault on 0xFFFF or let 0x10000 through.

The bench also walks indexes across the global and local table limits, so the last legal descriptor and the first illegal one are both hit. An off-by-one limit compare shows up as a wrong fault, or as a read where none should happen.

Index 0 is tried in both tables. A design that treated every index 0 as null, or no index 0 as null, fails there.

Descriptor words come from an address hash and offsets that wrap past 2^32 are used, so a swapped base byte or a wrong second-read address gives a wrong result. Starts issued during a fetch would show up as a second done or as a changed privilege level.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_RD_LO = 2'd1,
    FS_RD_HI = 2'd2
  } fetch_st_e;

  localparam logic [7:0] FLT_GP   = 8'd13;
  localparam logic [7:0] FLT_NONE = 8'd0;

  // gather the scattered 32-bit segment base out of a descriptor pair
  function automatic logic [31:0] desc_base(input logic [31:0] lo_w,
                                            input logic [31:0] hi_w);
    return {hi_w[31:24], hi_w[7:0], lo_w[31:16]};
  endfunction

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/seg_real_path.sv
module seg_real_path #(
  parameter int unsigned SEG_W   = 16,
  parameter int unsigned OFF_W   = 32,
  parameter int unsigned SHIFT   = 4,
  parameter int unsigned SPAN_W  = 16,
  parameter int unsigned OUT_W   = 32
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [OUT_W-1:0] addr,
  output logic             flt
);
  localparam int unsigned SUM_W = SEG_W + SHIFT + 1;

  logic [SUM_W-1:0] seg_sh;
  logic [SUM_W-1:0] sum;

  always_comb begin
    seg_sh = {1'b0, seg, {SHIFT{1'b0}}};
    sum    = seg_sh + SUM_W'(off[SPAN_W-1:0]);
    addr   = OUT_W'(sum);
    flt    = |off[OFF_W-1:SPAN_W];
  end
endmodule

// File: rtl/seg_sel_check.sv
module seg_sel_check #(
  parameter int unsigned SEL_W  = 16,
  parameter int unsigned BASE_W = 32,
  parameter int unsigned LIM_W  = 16
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [BASE_W-1:0] gdt_base,
  input  logic [LIM_W-1:0]  gdt_lim,
  input  logic [BASE_W-1:0] ldt_base,
  input  logic [LIM_W-1:0]  ldt_lim,
  output logic [1:0]        rpl,
  output logic              null_flt,
  output logic              lim_flt,
  output logic [BASE_W-1:0] desc_addr
);
  localparam int unsigned DSH   = 3;
  localparam int unsigned IDX_W = SEL_W - DSH;
  localparam int unsigned CMP_W = (SEL_W > LIM_W) ? SEL_W + 1 : LIM_W + 1;

  logic [IDX_W-1:0]  idx;
  logic              use_local;
  logic [BASE_W-1:0] tbl_base;
  logic [LIM_W-1:0]  tbl_lim;
  logic [SEL_W-1:0]  last_byte;

  always_comb begin
    idx       = sel[SEL_W-1:DSH];
    use_local = sel[2];
    rpl       = sel[1:0];
    tbl_base  = use_local ? ldt_base : gdt_base;
    tbl_lim   = use_local ? ldt_lim  : gdt_lim;
    last_byte = {idx, {DSH{1'b1}}};
    lim_flt   = CMP_W'(last_byte) > CMP_W'(tbl_lim);
    null_flt  = !use_local && (idx == '0);
    desc_addr = tbl_base + BASE_W'({idx, {DSH{1'b0}}});
  end
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] launch_addr,
  input  logic [ADDR_W-1:0] launch_off,
  output logic              busy,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic [31:0]       rd_data,
  output logic              fin,
  output logic [ADDR_W-1:0] fin_addr
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

  fetch_st_e         state_q, state_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [ADDR_W-1:0] off_q, off_n;
  logic [31:0]       lo_q, lo_n;

  always_comb begin
    state_n = state_q;
    addr_n  = addr_q;
    off_n   = off_q;
    lo_n    = lo_q;
    fin     = 1'b0;
    unique case (state_q)
      FS_IDLE: begin
        if (launch) begin
          state_n = FS_RD_LO;
          addr_n  = launch_addr;
          off_n   = launch_off;
        end
      end
      FS_RD_LO: begin
        if (rd_ready) begin
          lo_n    = rd_data;
          addr_n  = addr_q + WORD_STEP;
          state_n = FS_RD_HI;
        end
      end
      FS_RD_HI: begin
        if (rd_ready) begin
          fin     = 1'b1;
          state_n = FS_IDLE;
        end
      end
      default: state_n = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      addr_q  <= '0;
      off_q   <= '0;
      lo_q    <= '0;
    end else begin
      state_q <= state_n;
      addr_q  <= addr_n;
      off_q   <= off_n;
      lo_q    <= lo_n;
    end
  end

  assign busy     = (state_q != FS_IDLE);
  assign rd_valid = busy;
  assign rd_addr  = addr_q;
  assign fin_addr = ADDR_W'(desc_base(lo_q, rd_data)) + off_q;

  // R6
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  // R6
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_RD_LO) && rd_ready |=> rd_valid && (rd_addr == $past(rd_addr) + WORD_STEP));

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SEL_W  = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_prot,
  input  logic [SEL_W-1:0]  seg_sel,
  input  logic [ADDR_W-1:0] offset,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] lin_addr,
  output logic [1:0]        rpl_out,
  output logic              fault,
  output logic [7:0]        fault_code,
  input  logic              gdt_wr,
  input  logic              ldt_wr,
  input  logic [ADDR_W-1:0] tbl_base_in,
  input  logic [LIM_W-1:0]  tbl_limit_in,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ready,
  input  logic [31:0]       mem_rd_data
);
  localparam int unsigned REAL_SHIFT = 4;
  localparam int unsigned REAL_SPAN  = 16;
  localparam logic [ADDR_W-1:0] REAL_MAX =
    ADDR_W'(((1 << SEL_W) - 1) << REAL_SHIFT) + ADDR_W'((1 << REAL_SPAN) - 1);

  logic rst_s;

  seg_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s)
  );

  // table registers
  logic [ADDR_W-1:0] gdt_base_q, gdt_base_n, ldt_base_q, ldt_base_n;
  logic [LIM_W-1:0]  gdt_lim_q, gdt_lim_n, ldt_lim_q, ldt_lim_n;

  // result registers
  logic              done_q, done_n;
  logic [ADDR_W-1:0] lin_q, lin_n;
  logic [1:0]        rpl_q, rpl_n;
  logic              fault_q, fault_n;
  logic [7:0]        code_q, code_n;
  logic              mode_q, mode_n;

  logic [ADDR_W-1:0] real_addr;
  logic              real_flt;
  logic [1:0]        sel_rpl;
  logic              sel_null, sel_lim;
  logic [ADDR_W-1:0] sel_daddr;
  logic              f_busy, f_fin, launch;
  logic [ADDR_W-1:0] f_addr;
  logic              accept;

  seg_real_path #(
    .SEG_W (SEL_W), .OFF_W (ADDR_W), .SHIFT (REAL_SHIFT),
    .SPAN_W(REAL_SPAN), .OUT_W (ADDR_W)
  ) u_real (
    .seg  (seg_sel),
    .off  (offset),
    .addr (real_addr),
    .flt  (real_flt)
  );

  seg_sel_check #(
    .SEL_W (SEL_W), .BASE_W (ADDR_W), .LIM_W (LIM_W)
  ) u_sel (
    .sel       (seg_sel),
    .gdt_base  (gdt_base_q),
    .gdt_lim   (gdt_lim_q),
    .ldt_base  (ldt_base_q),
    .ldt_lim   (ldt_lim_q),
    .rpl       (sel_rpl),
    .null_flt  (sel_null),
    .lim_flt   (sel_lim),
    .desc_addr (sel_daddr)
  );

  seg_desc_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_s),
    .launch      (launch),
    .launch_addr (sel_daddr),
    .launch_off  (offset),
    .busy        (f_busy),
    .rd_valid    (mem_rd_valid),
    .rd_addr     (mem_rd_addr),
    .rd_ready    (mem_rd_ready),
    .rd_data     (mem_rd_data),
    .fin         (f_fin),
    .fin_addr    (f_addr)
  );

  assign accept = start && !f_busy;

  always_comb begin
    gdt_base_n = gdt_base_q;
    gdt_lim_n  = gdt_lim_q;
    ldt_base_n = ldt_base_q;
    ldt_lim_n  = ldt_lim_q;
    if (gdt_wr) begin
      gdt_base_n = tbl_base_in;
      gdt_lim_n  = tbl_limit_in;
    end
    if (ldt_wr) begin
      ldt_base_n = tbl_base_in;
      ldt_lim_n  = tbl_limit_in;
    end
  end

  always_comb begin
    done_n  = 1'b0;
    lin_n   = lin_q;
    rpl_n   = rpl_q;
    fault_n = fault_q;
    code_n  = code_q;
    mode_n  = mode_q;
    launch  = 1'b0;
    if (accept) begin
      mode_n = mode_prot;
      if (!mode_prot) begin
        done_n = 1'b1;
        rpl_n  = 2'd0;
        if (real_flt) begin
          fault_n = 1'b1;
          code_n  = FLT_GP;
          lin_n   = '0;
        end else begin
          fault_n = 1'b0;
          code_n  = FLT_NONE;
          lin_n   = real_addr;
        end
      end else begin
        rpl_n = sel_rpl;
        if (sel_null || sel_lim) begin
          done_n  = 1'b1;
          fault_n = 1'b1;
          code_n  = FLT_GP;
          lin_n   = '0;
        end else begin
          launch = 1'b1;
        end
      end
    end
    if (f_fin) begin
      done_n  = 1'b1;
      fault_n = 1'b0;
      code_n  = FLT_NONE;
      lin_n   = f_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      gdt_base_q <= '0;
      gdt_lim_q  <= '0;
      ldt_base_q <= '0;
      ldt_lim_q  <= '0;
      done_q     <= 1'b0;
      lin_q      <= '0;
      rpl_q      <= '0;
      fault_q    <= 1'b0;
      code_q     <= FLT_NONE;
      mode_q     <= 1'b0;
    end else begin
      gdt_base_q <= gdt_base_n;
      gdt_lim_q  <= gdt_lim_n;
      ldt_base_q <= ldt_base_n;
      ldt_lim_q  <= ldt_lim_n;
      done_q     <= done_n;
      lin_q      <= lin_n;
      rpl_q      <= rpl_n;
      fault_q    <= fault_n;
      code_q     <= code_n;
      mode_q     <= mode_n;
    end
  end

  assign busy       = f_busy;
  assign done       = done_q;
  assign lin_addr   = lin_q;
  assign rpl_out    = rpl_q;
  assign fault      = fault_q;
  assign fault_code = code_q;

  // R2
  real_latency_chk: assert property (@(posedge clk) disable iff (!rst_s)
    accept && !mode_prot |=> done && !busy && !mem_rd_valid);

  // R3
  real_range_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done && !fault && !mode_q |-> lin_addr <= REAL_MAX);

  // R4
  fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done && fault |-> (lin_addr == '0) && (fault_code == FLT_GP));

  // R7
  early_reject_chk: assert property (@(posedge clk) disable iff (!rst_s)
    accept && mode_prot && (sel_null || sel_lim) |=> done && fault && !mem_rd_valid);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_s)
    start && busy |=> rpl_out == $past(rpl_out));

endmodule

// File: tb/sim_seg_xlate_unit.sv
module sim_seg_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, mode_prot, gdt_wr, ldt_wr;
  logic [15:0] seg_sel, tbl_limit_in;
  logic [31:0] offset, tbl_base_in;
  logic        busy, done, fault, mem_rd_valid;
  logic [31:0] lin_addr, mem_rd_addr;
  logic [1:0]  rpl_out;
  logic [7:0]  fault_code;
  logic        mem_rd_ready;
  logic [31:0] mem_rd_data;

  always #4 clk = ~clk;

  seg_xlate_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_prot(mode_prot),
    .seg_sel(seg_sel), .offset(offset), .busy(busy), .done(done),
    .lin_addr(lin_addr), .rpl_out(rpl_out), .fault(fault),
    .fault_code(fault_code), .gdt_wr(gdt_wr), .ldt_wr(ldt_wr),
    .tbl_base_in(tbl_base_in), .tbl_limit_in(tbl_limit_in),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'hC3A5_0F1E;
  endfunction

  // memory model: drives ready at the falling edge, handshake at next rise
  int          n_reads  = 0;
  int          wait_cnt = 0;
  int          fix_wait = -1;
  logic [31:0] rd_log [2];

  always @(negedge clk) begin
    mem_rd_ready = 1'b0;
    if (mem_rd_valid) begin
      if (wait_cnt <= 0) begin
        mem_rd_ready = 1'b1;
        mem_rd_data  = mem_word(mem_rd_addr);
        rd_log[n_reads % 2] = mem_rd_addr;
        n_reads++;
        wait_cnt = (fix_wait >= 0) ? fix_wait : (n_reads % 3);
      end else begin
        wait_cnt--;
      end
    end
  end

  // results of the last request
  bit          r_done;
  int          r_lat;
  logic [31:0] r_lin;
  logic        r_fault;
  logic [7:0]  r_code;
  logic [1:0]  r_rpl;
  int          r_reads;

  task automatic do_req(input logic m, input logic [15:0] s, input logic [31:0] o);
    int base_reads;
    @(negedge clk);
    base_reads = n_reads;
    mode_prot = m; seg_sel = s; offset = o; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r_done = 1'b0; r_lat = 1;
    for (int i = 0; i < 40; i++) begin
      if (done) begin
        r_done = 1'b1;
        break;
      end
      @(negedge clk);
      r_lat++;
    end
    r_lin = lin_addr; r_fault = fault; r_code = fault_code; r_rpl = rpl_out;
    r_reads = n_reads - base_reads;
  endtask

  task automatic wr_tbl(input bit loc, input logic [31:0] b, input logic [15:0] l);
    @(negedge clk);
    tbl_base_in = b; tbl_limit_in = l;
    gdt_wr = !loc; ldt_wr = loc;
    @(negedge clk);
    gdt_wr = 1'b0; ldt_wr = 1'b0;
  endtask

  task automatic prot_case(input bit loc, input logic [31:0] tb, input logic [15:0] tl,
                           input int idx, input logic [31:0] o);
    logic [15:0] s;
    logic [31:0] da, lo, hi, bs;
    bit          bad;
    s   = {idx[12:0], loc, 2'(idx % 4)};
    bad = ((idx * 8 + 7) > int'(tl)) || (!loc && idx == 0);
    do_req(1'b1, s, o);
    chk(r_done, "R9 done seen", 32'(r_done), 32'd1);
    chk(r_rpl == 2'(idx % 4), "R5 rpl passthrough", 32'(r_rpl), 32'(idx % 4));
    if (bad) begin
      if (!loc && idx == 0)
        chk(r_fault && r_code == 8'd13 && r_reads == 0, "R8 null selector",
            {r_code, 23'd0, r_fault}, {8'd13, 23'd0, 1'b1});
      else
        chk(r_fault && r_code == 8'd13 && r_reads == 0 && r_lat == 1, "R7 limit fault",
            32'(r_reads), 32'd0);
      chk(r_lin == 32'd0, "R7 no address on fault", r_lin, 32'd0);
    end else begin
      da = tb + 32'(idx) * 32'd8;
      lo = mem_word(da);
      hi = mem_word(da + 32'd4);
      bs = {hi[31:24], hi[7:0], lo[31:16]};
      chk(!r_fault && r_lin == bs + o, "R9 protected address", r_lin, bs + o);
      chk(r_reads == 2 && rd_log[0] == da && rd_log[1] == da + 32'd4,
          "R6 descriptor addresses", rd_log[1], da + 32'd4);
      if (loc && idx == 0)
        chk(!r_fault, "R8 local index 0 allowed", 32'(r_fault), 32'd0);
    end
  endtask

  initial begin
    logic [31:0] offs [7];
    logic [31:0] exp;
    logic [15:0] sg;
    int          dones;
    logic [31:0] da, lo, hi;
    offs[0] = 32'h0; offs[1] = 32'h1; offs[2] = 32'h7FFF; offs[3] = 32'hFFFF;
    offs[4] = 32'h10000; offs[5] = 32'hFFFF_FFFF; offs[6] = 32'h0001_2345;
    rst_n = 1'b0; start = 1'b0; mode_prot = 1'b0; seg_sel = '0; offset = '0;
    gdt_wr = 1'b0; ldt_wr = 1'b0; tbl_base_in = '0; tbl_limit_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!done && !busy && !fault && !mem_rd_valid && lin_addr == 0, "R1 reset outputs",
        {lin_addr[27:0], done, busy, fault, mem_rd_valid}, 32'd0);
    do_req(1'b1, 16'h0008, 32'h10);
    chk(r_fault && r_reads == 0, "R1 reset table limit 0", 32'(r_reads), 32'd0);

    // R2 R4 real-mode sweep
    for (int k = 0; k < 17; k++) begin
      sg = (k == 16) ? 16'hFFFF : 16'(k * 16'h0FFF);
      for (int j = 0; j < 7; j++) begin
        do_req(1'b0, sg, offs[j]);
        if (offs[j] > 32'hFFFF) begin
          chk(r_done && r_lat == 1 && r_fault && r_code == 8'd13 && r_lin == 0,
              "R4 real offset fault", r_lin, 32'd0);
        end else begin
          exp = {12'd0, sg, 4'd0} + {16'd0, offs[j][15:0]};
          chk(r_done && r_lat == 1 && !r_fault && r_lin == exp && r_reads == 0,
              "R2 real address", r_lin, exp);
        end
      end
    end
    do_req(1'b0, 16'hFFFF, 32'h0000_FFFF);
    chk(r_lin == 32'h0010_FFEF, "R3 carry into bit 20", r_lin, 32'h0010_FFEF);
    chk(!busy, "R2 busy low in real mode", 32'(busy), 32'd0);

    // R11 table loads, then R5 R6 R7 R8 R9 sweeps
    wr_tbl(1'b0, 32'h0010_0000, 16'h00FF);
    wr_tbl(1'b1, 32'h2000_0000, 16'h003F);
    for (int i = 0; i <= 40; i++)
      prot_case(1'b0, 32'h0010_0000, 16'h00FF, i, 32'(i) * 32'h0F0F_0F0F + 32'hF000_0000);
    for (int i = 0; i <= 10; i++)
      prot_case(1'b1, 32'h2000_0000, 16'h003F, i, 32'(i) * 32'h0101_0101 + 32'h1234);
    wr_tbl(1'b1, 32'hFFFF_FFF0, 16'h000F);
    prot_case(1'b1, 32'hFFFF_FFF0, 16'h000F, 1, 32'h0000_0040);
    prot_case(1'b1, 32'hFFFF_FFF0, 16'h000F, 2, 32'h0000_0040);
    chk(r_fault, "R11 local limit reload", 32'(r_fault), 32'd1);

    // R10 start ignored while busy
    fix_wait = 3;
    @(negedge clk);
    mode_prot = 1'b1; seg_sel = {13'd5, 1'b0, 2'd2}; offset = 32'h100; start = 1'b1;
    @(negedge clk);
    mode_prot = 1'b0; seg_sel = 16'h1234; offset = 32'h5;
    dones = 0;
    for (int i = 0; i < 3; i++) begin
      if (done) dones++;
      @(negedge clk);
    end
    start = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (done) begin
        dones++;
        r_lin = lin_addr; r_rpl = rpl_out;
      end
      @(negedge clk);
    end
    da = 32'h0010_0000 + 32'd40;
    lo = mem_word(da); hi = mem_word(da + 32'd4);
    exp = {hi[31:24], hi[7:0], lo[31:16]} + 32'h100;
    chk(dones == 1, "R10 single done", 32'(dones), 32'd1);
    chk(r_lin == exp && r_rpl == 2'd2, "R10 result of first request", r_lin, exp);
    fix_wait = -1;

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule